// File: doc/BRIEF.md
# Data Tenure Beat Acknowledge Controller

This block runs the slave side of the data phase on a 64-bit system bus. It takes one transfer request at a time. Each request carries three things: a burst flag, the transfer size, and the port width of the target memory. From these it paces the data beats, using a memory-ready input to decide when each beat may move.

The block drives two beat strobes. The data-valid strobe pulses once for every port-sized movement of data. The transfer-acknowledge strobe pulses only when a whole transfer-sized beat is complete. If the transfer is wider than the memory port, each beat is split into sub-beats. The data-valid strobe pulses alone on every sub-beat except the last one. On the last sub-beat, data-valid and transfer-acknowledge pulse together.

A burst moves eight transfer-sized beats, and the eighth acknowledge ends the burst. A bus monitor counts the cycles that pass without any progress. If that count reaches a limit, the monitor ends a hung tenure with a one-cycle transfer-error strobe.

Top module: `beat_ack_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `beat_valid`, `xfer_ack` and `xfer_err` are all low.
- R2: A single transfer whose size code is less than or equal to the port code produces exactly one cycle in which `beat_valid` and `xfer_ack` are both high. Size and port codes use the encoding 0=8, 1=16, 2=32, 3=64 bits.
- R3: When the size code `s` is larger than the port code `p`, every transfer-sized beat produces 2^(s-p) `beat_valid` pulses. `xfer_ack` is high only on the last of these pulses.
- R4: When `req_burst` is high, the tenure moves `BURST_LEN` beats (default 8) and produces one `xfer_ack` per beat. The tenure ends on the cycle of the last acknowledge, when `busy` falls.
- R5: `xfer_ack` is never high unless `beat_valid` is high in the same cycle.
- R6: A sub-beat advances only on a clock edge at which the tenure is active and `mem_ready` is high. The resulting strobes are high for exactly the one cycle after that edge.
- R7: A request is accepted only when the block is idle. `busy` rises in the cycle after acceptance and stays high until the final strobe or the error strobe. Requests presented while `busy` is high have no effect on the strobes.
- R8: After `TMO_CYCLES` (default 255) consecutive active edges with `mem_ready` low, `xfer_err` pulses for one cycle. In that cycle `xfer_ack` and `beat_valid` are low and `busy` is low, so the block is back in idle.
- R9: The stall count restarts at every sub-beat advance. A stall of `TMO_CYCLES-1` cycles between advances does not raise `xfer_err`.
- R10: `xfer_err` is never raised unless a tenure was active on the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Transfer request present |
| req_burst | input | 1 | Request is a burst of BURST_LEN beats |
| req_size | input | 2 | Transfer size code (0=8, 1=16, 2=32, 3=64 bits) |
| req_port | input | 2 | Target port width code (same encoding) |
| mem_ready | input | 1 | Memory can move a sub-beat on this edge |
| busy | output | 1 | Tenure in progress; new requests held off |
| beat_valid | output | 1 | One-cycle strobe per sub-beat movement |
| xfer_ack | output | 1 | One-cycle strobe per completed transfer-sized beat |
| xfer_err | output | 1 | One-cycle strobe when the bus monitor aborts a tenure |

## Verification
Directed transfers cover four cases. A port at least as wide as the size gives a single combined strobe. A byte port under a 64-bit size gives eight pulses before the acknowledge. A 32-bit port in a burst checks the sub-beat split and the eight-beat count working together. A byte-port burst of sixty-four pulses checks how the two counters nest. Random requests with random memory-ready pacing, and junk requests issued while busy, separate correct pacing and hold-off from strobes that are counted wrongly or placed wrongly. Three stall patterns check the bus monitor: a hang before any beat, a hang partway through, and a stall exactly one cycle short of the limit. These show whether the error fires on the right cycle, aborts without an acknowledge, and restarts its count at each beat.

// File: rtl/bt_pkg.sv
package bt_pkg;

   typedef enum logic {
      ST_IDLE   = 1'b0,
      ST_ACTIVE = 1'b1
   } bt_state_e;

   // number of extra sub-beat doublings for a size/port code pair
   function automatic int unsigned split_shift(input int unsigned size_code,
                                               input int unsigned port_code);
      return (size_code > port_code) ? (size_code - port_code) : 0;
   endfunction

endpackage

// File: rtl/bt_down_counter.sv
module bt_down_counter #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic         at_zero
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (dec && (cnt_q != '0))
         cnt_q <= cnt_q - 1'b1;
   end

   assign at_zero = (cnt_q == '0);

endmodule

// File: rtl/bt_bus_monitor.sv
module bt_bus_monitor #(
   parameter int TMO_CYCLES = 255
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic advance,
   output logic expire
);

   generate
      if (TMO_CYCLES == 0) begin : g_off
         assign expire = 1'b0;
      end else begin : g_on
         localparam int CW = $clog2(TMO_CYCLES + 1);
         localparam logic [CW-1:0] LIMIT = CW'(TMO_CYCLES);
         logic [CW-1:0] stall_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               stall_q <= '0;
            else if (!active || advance || expire)
               stall_q <= '0;
            else
               stall_q <= stall_q + 1'b1;
         end

         assign expire = active && !advance && ((stall_q + 1'b1) >= LIMIT);
      end
   endgenerate

endmodule

// File: rtl/beat_ack_ctrl.sv
module beat_ack_ctrl #(
   parameter int DATA_W     = 64,
   parameter int BURST_LEN  = 8,
   parameter int TMO_CYCLES = 255
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic req_burst,
   input  logic [$clog2($clog2(DATA_W/8)+1)-1:0] req_size,
   input  logic [$clog2($clog2(DATA_W/8)+1)-1:0] req_port,
   input  logic mem_ready,
   output logic busy,
   output logic beat_valid,
   output logic xfer_ack,
   output logic xfer_err
);
   import bt_pkg::*;

   localparam int MAX_SUB = DATA_W / 8;
   localparam int SUB_W   = (MAX_SUB > 1) ? $clog2(MAX_SUB) : 1;
   localparam int BEAT_W  = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

   initial begin
      if (DATA_W < 16 || (DATA_W & (DATA_W - 1)) != 0)
         $error("beat_ack_ctrl: DATA_W must be a power of two of at least 16");
      if (BURST_LEN < 1)
         $error("beat_ack_ctrl: BURST_LEN must be at least 1");
      if (TMO_CYCLES < 0)
         $error("beat_ack_ctrl: TMO_CYCLES must not be negative");
   end

   bt_state_e    state_q;
   logic         active, accept, advance, expire;
   logic         sub_last, beat_last;
   logic [SUB_W-1:0] sub_reload_q, sub_start;
   logic [BEAT_W-1:0] beat_start;
   logic         valid_q, ack_q, err_q;

   assign active  = (state_q == ST_ACTIVE);
   assign accept  = !active && req_valid;
   assign advance = active && mem_ready;

   always_comb begin
      sub_start  = SUB_W'((1 << split_shift(int'(req_size), int'(req_port))) - 1);
      beat_start = req_burst ? BEAT_W'(BURST_LEN - 1) : '0;
   end

   bt_down_counter #(.W(SUB_W)) i_sub_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept || (advance && sub_last)),
      .load_val (accept ? sub_start : sub_reload_q),
      .dec      (advance),
      .at_zero  (sub_last)
   );

   bt_down_counter #(.W(BEAT_W)) i_beat_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_val (beat_start),
      .dec      (advance && sub_last),
      .at_zero  (beat_last)
   );

   bt_bus_monitor #(.TMO_CYCLES(TMO_CYCLES)) i_mon (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (active),
      .advance (advance),
      .expire  (expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         sub_reload_q <= '0;
         valid_q      <= 1'b0;
         ack_q        <= 1'b0;
         err_q        <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         ack_q   <= 1'b0;
         err_q   <= 1'b0;
         if (accept) begin
            state_q      <= ST_ACTIVE;
            sub_reload_q <= sub_start;
         end else if (advance) begin
            valid_q <= 1'b1;
            ack_q   <= sub_last;
            if (sub_last && beat_last)
               state_q <= ST_IDLE;
         end else if (expire) begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
         end
      end
   end

   assign busy       = active;
   assign beat_valid = valid_q;
   assign xfer_ack   = ack_q;
   assign xfer_err   = err_q;

endmodule

// File: rtl/beat_ack_ctrl_chk.sv
module beat_ack_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic mem_ready,
   input logic busy,
   input logic beat_valid,
   input logic xfer_ack,
   input logic xfer_err
);

   p_ack_with_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_ack |-> beat_valid);

   p_valid_paced_r6: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid |-> ($past(mem_ready) && $past(busy)));

   p_err_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_err |-> (!xfer_ack && !beat_valid && !busy));

   p_err_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_err |=> !xfer_err);

   p_err_from_tenure_r10: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_err |-> $past(busy));

   p_busy_from_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req_valid));

endmodule

bind beat_ack_ctrl beat_ack_ctrl_chk i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .mem_ready  (mem_ready),
   .busy       (busy),
   .beat_valid (beat_valid),
   .xfer_ack   (xfer_ack),
   .xfer_err   (xfer_err)
);

// File: tb/test_beat_ack_ctrl.sv
module test_beat_ack_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int TMO        = 255;
   localparam int BLEN       = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_burst = 1'b0, mem_ready = 1'b0;
   logic [1:0] req_size = '0, req_port = '0;
   logic busy, beat_valid, xfer_ack, xfer_err;

   int n_chk = 0;
   int n_bad = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cycles <= cycles + 1;

   beat_ack_ctrl #(.DATA_W(64), .BURST_LEN(BLEN), .TMO_CYCLES(TMO)) i_beat_ack_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_burst(req_burst),
      .req_size(req_size), .req_port(req_port), .mem_ready(mem_ready),
      .busy(busy), .beat_valid(beat_valid), .xfer_ack(xfer_ack), .xfer_err(xfer_err)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int subs_of(input int sz, input int pt);
      return (sz > pt) ? (1 << (sz - pt)) : 1;
   endfunction

   // hang_after: valid pulses before memory stops responding (-1 = never)
   // stall: fixed stall cycles before each advance (0 = random pacing)
   task automatic run_xfer(input bit burst, input int sz, input int pt,
                           input int hang_after, input int stall, input string tag);
      int nsub = subs_of(sz, pt);
      int nbeat = burst ? BLEN : 1;
      int total = nsub * nbeat;
      int nv = 0, na = 0, ne = 0, cyc = 0, last_v = 0, err_cyc = -1;
      int sctr = 0;
      bit pr, pb, rdy, exp_err;
      @(negedge clk);
      req_valid = 1'b1; req_burst = burst; req_size = 2'(sz); req_port = 2'(pt);
      mem_ready = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      check(busy === 1'b1, {"R7 busy after accept ", tag}, int'(busy), 1);
      rdy = 1'b0;
      forever begin
         if (hang_after >= 0 && nv >= hang_after) rdy = 1'b0;
         else if (stall > 0) begin
            rdy = (sctr == stall);
            sctr = rdy ? 0 : sctr + 1;
         end else rdy = ($urandom % 100) < 60;
         mem_ready = rdy;
         // junk request while busy must be ignored (R7)
         req_valid = ($urandom % 4) == 0;
         req_burst = ~burst; req_size = 2'($urandom); req_port = 2'($urandom);
         pr = rdy; pb = busy;
         @(negedge clk);
         cyc++;
         if (xfer_ack && !beat_valid)
            check(1'b0, {"R5 ack without valid ", tag}, 0, 1);
         if (beat_valid) begin
            check(pr && pb, {"R6 valid without ready edge ", tag}, int'(pr), 1);
            nv++; last_v = cyc;
         end
         if (xfer_ack) na++;
         if (xfer_err) begin
            ne++; err_cyc = cyc;
            check(!xfer_ack && !beat_valid, {"R8 strobe with error ", tag},
                  int'(xfer_ack | beat_valid), 0);
         end
         if (!busy || cyc > 4 * TMO + 4 * total) break;
      end
      req_valid = 1'b0; mem_ready = 1'b0;
      exp_err = (hang_after >= 0) && (hang_after < total);
      if (exp_err) begin
         check(ne == 1, {"R8 error count ", tag}, ne, 1);
         check(nv == hang_after, {"R8 valid before hang ", tag}, nv, hang_after);
         check(na == hang_after / nsub, {"R8 acks before hang ", tag}, na, hang_after / nsub);
         check(err_cyc == last_v + TMO, {"R8 error cycle ", tag}, err_cyc, last_v + TMO);
      end else begin
         check(ne == 0, {"R9 no error ", tag}, ne, 0);
         check(nv == total, {"R3 valid count ", tag}, nv, total);
         check(na == nbeat, {"R4 ack count ", tag}, na, nbeat);
         check(last_v == cyc, {"R4 busy falls with last strobe ", tag}, last_v, cyc);
      end
      @(negedge clk);
      check(!busy && !beat_valid && !xfer_ack && !xfer_err, {"R10 quiet after end ", tag},
            int'({busy, beat_valid, xfer_ack, xfer_err}), 0);
   endtask

   initial begin : watchdog
      wait (cycles > 150000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      check(!busy && !beat_valid && !xfer_ack && !xfer_err, "R1 in reset",
            int'({busy, beat_valid, xfer_ack, xfer_err}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !beat_valid && !xfer_ack && !xfer_err, "R1 after reset",
            int'({busy, beat_valid, xfer_ack, xfer_err}), 0);
      // R2: port as wide as size
      run_xfer(1'b0, 3, 3, -1, 0, "R2 64on64");
      run_xfer(1'b0, 0, 3, -1, 0, "R2 8on64");
      // R3: narrow port
      run_xfer(1'b0, 3, 0, -1, 0, "R3 64on8");
      run_xfer(1'b0, 2, 1, -1, 0, "R3 32on16");
      // R4: bursts
      run_xfer(1'b1, 3, 2, -1, 0, "R4 burst 32port");
      run_xfer(1'b1, 3, 0, -1, 0, "R4 burst 8port");
      // R8: hangs
      run_xfer(1'b0, 3, 3, 0, 0, "R8 hang at start");
      run_xfer(1'b1, 3, 1, 5, 0, "R8 hang mid burst");
      // R9: stall one short of limit between every advance
      run_xfer(1'b0, 3, 2, -1, TMO - 1, "R9 near limit");
      // R6/R7 random
      for (int i = 0; i < 24; i++)
         run_xfer(1'($urandom), int'($urandom % 4), int'($urandom % 4), -1, 0, "R6 random");
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule